// File: doc/BRIEF.md
# Shared PCI Bus Arbiter with Alternating Priority and Bus Parking

This block decides which requester owns a shared PCI bus. There is one host CPU requester and a parameterised number of add-in slot requesters, four by default. Each requester has a request input and a grant output. A single-cycle strobe marks each arbitration point. On that strobe the arbiter registers a new decision, and the grant outputs then hold steady until the next strobe.

Configuration inputs decide who may be granted and who is favoured. A per-slot enable removes a slot from arbitration. A CPU-favour bit, and a one-hot favoured-slot selector, let a chosen requester take every other grant. The remaining grants rotate round-robin over a ring that holds the CPU and then slot 0 up to the last slot. When no eligible requester is asking for the bus, the grant parks on a requester: either the CPU, or the requester that owned the bus last, as a configuration bit selects.

Top module: `pci_park_arb`

## Requirements
- R1: While reset is held and after it is released, only the CPU grant is asserted, and this lasts until the first arbitration strobe.
- R2: Exactly one grant output (the CPU or one slot) is asserted in every cycle.
- R3: Grants change only in the cycle after `arb_adv` was high at a rising clock edge. With `arb_adv` low, all grants hold their values.
- R4: A slot whose `slot_en` bit is 0 at an arbitration strobe is never granted, and the bus is never parked on it.
- R5: On a favoured turn, if `cpu_prio` is 1 and `cpu_req` is 1, the CPU wins. Otherwise the favoured slot wins if it is enabled and requesting. A favoured grant ends the favoured turn.
- R6: After a round-robin grant, the next strobe is a favoured turn. After a favoured grant, the next strobe is a normal turn. The first strobe after reset is a favoured turn.
- R7: On a favoured turn with no favoured requester asking, the grant goes round-robin, and the next strobe is still a favoured turn.
- R8: A round-robin grant goes to the first eligible requester found by walking the ring (index 0 = CPU, index i+1 = slot i), starting one past the last round-robin winner. The CPU is eligible when it requests. A slot is eligible when it requests and is enabled. The ring pointer moves only on round-robin grants, and it starts at the CPU after reset.
- R9: With no eligible request and `park_last` = 0, the CPU is granted.
- R10: With no eligible request and `park_last` = 1, the current owner keeps the grant. If the current owner is a slot whose enable is now 0, the grant moves to the CPU instead.
- R11: Bit i of `prio_slot` selects slot i as the favoured slot. If several bits are set, the lowest one wins. A value of 0 disables slot favouring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_adv | input | 1 | Arbitration strobe; a new grant is registered when high |
| cpu_req | input | 1 | CPU bus request |
| slot_req | input | NSLOT | Slot bus requests |
| slot_en | input | NSLOT | Per-slot arbitration enables |
| cpu_prio | input | 1 | CPU takes every other grant when set |
| prio_slot | input | NSLOT | One-hot favoured slot select; zero disables |
| park_last | input | 1 | 0: park on CPU; 1: park on last owner |
| cpu_gnt | output | 1 | CPU grant |
| slot_gnt | output | NSLOT | Slot grants |

## Verification
The favoured-turn logic, the round-robin rotation and the parking decision all resolve in the same arbitration strobe. The collisions of interest are:
- a favoured turn on which the favoured requester is silent while others ask, so the turn falls to round-robin and must stay pending;
- a parking strobe on which the owner's slot enable has just been cleared.

The bench sweeps CPU favouring, every favoured-slot select, both parking modes and several enable patterns. Pseudo-random request bursts are mixed with idle strobes and skipped strobes. An arithmetic model of the turn flag, the ring pointer and the owner predicts every grant, and each mismatch is reported under the requirement that decided that strobe.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
   // where the registered grant of a strobe came from
   typedef enum logic [1:0] {
      SRC_PARK = 2'd0,
      SRC_FAV  = 2'd1,
      SRC_RR   = 2'd2
   } grant_src_e;
endpackage

// File: rtl/arb_fav_pick.sv
module arb_fav_pick #(
   parameter int NSLOT = 4
) (
   input  logic             cpu_req,
   input  logic             cpu_prio,
   input  logic [NSLOT-1:0] slot_elig,
   input  logic [NSLOT-1:0] prio_sel,
   output logic             hit,
   output logic [NSLOT:0]   win_vec
);
   // CPU favour beats slot favour; among slots the lowest selected wins
   always_comb begin
      hit     = 1'b0;
      win_vec = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (prio_sel[i] && slot_elig[i]) begin
            hit          = 1'b1;
            win_vec      = '0;
            win_vec[i+1] = 1'b1;
         end
      end
      if (cpu_prio && cpu_req) begin
         hit        = 1'b1;
         win_vec    = '0;
         win_vec[0] = 1'b1;
      end
   end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
   parameter int NREQ = 5,
   parameter int IW   = $clog2(NREQ)
) (
   input  logic [NREQ-1:0] elig,
   input  logic [IW-1:0]   last_idx,
   output logic            hit,
   output logic [IW-1:0]   win_idx,
   output logic [NREQ-1:0] win_vec
);
   function automatic logic [IW-1:0] wrap(input int a);
      return IW'(a % NREQ);
   endfunction

   // walk from farthest to nearest so the nearest eligible entry is kept
   always_comb begin
      hit     = 1'b0;
      win_idx = '0;
      for (int k = NREQ; k >= 1; k--) begin
         if (elig[wrap(int'(last_idx) + k)]) begin
            hit     = 1'b1;
            win_idx = wrap(int'(last_idx) + k);
         end
      end
      win_vec = hit ? (NREQ'(1) << win_idx) : '0;
   end
endmodule

// File: rtl/pci_park_arb.sv
module pci_park_arb
   import pci_arb_pkg::*;
#(
   parameter int NSLOT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arb_adv,
   input  logic             cpu_req,
   input  logic [NSLOT-1:0] slot_req,
   input  logic [NSLOT-1:0] slot_en,
   input  logic             cpu_prio,
   input  logic [NSLOT-1:0] prio_slot,
   input  logic             park_last,
   output logic             cpu_gnt,
   output logic [NSLOT-1:0] slot_gnt
);
   localparam int NREQ = NSLOT + 1;
   localparam int IW   = $clog2(NREQ);

   if (NSLOT < 1 || NSLOT > 15) begin : g_bad_nslot
      $error("pci_park_arb: NSLOT must lie in 1..15");
   end

   logic [NREQ-1:0] elig;
   logic [NREQ-1:0] gnt_q, gnt_d;
   logic            fav_turn_q;
   logic [IW-1:0]   rr_last_q;
   logic            fav_hit, rr_hit, owner_ok;
   logic [NREQ-1:0] fav_vec, rr_vec;
   logic [IW-1:0]   rr_idx;
   grant_src_e      src;

   assign elig = {slot_req & slot_en, cpu_req};

   arb_fav_pick #(.NSLOT(NSLOT)) i_fav (
      .cpu_req  (cpu_req),
      .cpu_prio (cpu_prio),
      .slot_elig(elig[NREQ-1:1]),
      .prio_sel (prio_slot),
      .hit      (fav_hit),
      .win_vec  (fav_vec)
   );

   arb_rr_pick #(.NREQ(NREQ), .IW(IW)) i_rr (
      .elig    (elig),
      .last_idx(rr_last_q),
      .hit     (rr_hit),
      .win_idx (rr_idx),
      .win_vec (rr_vec)
   );

   // the present owner may keep a parked grant only while still enabled
   assign owner_ok = |(gnt_q & {slot_en, 1'b1});

   always_comb begin
      if (fav_turn_q && fav_hit) begin
         src   = SRC_FAV;
         gnt_d = fav_vec;
      end else if (rr_hit) begin
         src   = SRC_RR;
         gnt_d = rr_vec;
      end else begin
         src   = SRC_PARK;
         gnt_d = (park_last && owner_ok) ? gnt_q : NREQ'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q      <= NREQ'(1);
         fav_turn_q <= 1'b1;
         rr_last_q  <= '0;
      end else if (arb_adv) begin
         gnt_q <= gnt_d;
         case (src)
            SRC_FAV: fav_turn_q <= 1'b0;
            SRC_RR: begin
               fav_turn_q <= 1'b1;
               rr_last_q  <= rr_idx;
            end
            default: ;
         endcase
      end
   end

   assign cpu_gnt  = gnt_q[0];
   assign slot_gnt = gnt_q[NREQ-1:1];

   // R2
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({slot_gnt, cpu_gnt}) == 1);

   // R3
   hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_adv |=> $stable({slot_gnt, cpu_gnt}));

   // R9
   park_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_adv && elig == '0 && !park_last) |=> cpu_gnt);

   // R5
   fav_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_adv && fav_turn_q && cpu_prio && cpu_req) |=> cpu_gnt);

   // R6
   turn_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_adv && fav_turn_q && fav_hit) |=> !fav_turn_q);

   for (genvar s = 0; s < NSLOT; s++) begin : g_en_chk
      // R4
      dis_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (arb_adv && !slot_en[s]) |=> !slot_gnt[s]);
   end
endmodule

// File: tb/test_pci_park_arb.sv
module test_pci_park_arb;
   localparam int NS = 4;
   localparam int NR = NS + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          arb_adv = 1'b0;
   logic          cpu_req = 1'b0;
   logic [NS-1:0] slot_req = '0;
   logic [NS-1:0] slot_en = '1;
   logic          cpu_prio = 1'b0;
   logic [NS-1:0] prio_slot = '0;
   logic          park_last = 1'b0;
   logic          cpu_gnt;
   logic [NS-1:0] slot_gnt;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   // bench model state
   logic [NR-1:0] m_gnt = NR'(1);
   bit            m_turn = 1'b1;
   int            m_last = 0;
   logic [15:0]   lfsr = 16'hACE1;

   always #4 clk = ~clk;

   pci_park_arb #(.NSLOT(NS)) i_pci_park_arb (
      .clk(clk), .rst_n(rst_n), .arb_adv(arb_adv), .cpu_req(cpu_req),
      .slot_req(slot_req), .slot_en(slot_en), .cpu_prio(cpu_prio),
      .prio_slot(prio_slot), .park_last(park_last),
      .cpu_gnt(cpu_gnt), .slot_gnt(slot_gnt)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL R3 watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [NR-1:0] got, input logic [NR-1:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, got, exp);
      end
   endtask

   // called at a falling edge: drive, predict, wait one cycle, compare
   task automatic step(input bit adv, input bit creq, input logic [NS-1:0] sreq);
      logic [NR-1:0] el, exp, got;
      string tag;
      bit fh;
      int fi, j, nl;
      bit nt, rh;
      arb_adv = adv; cpu_req = creq; slot_req = sreq;
      el = {sreq & slot_en, creq};
      exp = m_gnt; tag = "R3"; nt = m_turn; nl = m_last;
      if (adv) begin
         fh = 1'b0; fi = 0;
         if (m_turn) begin
            if (cpu_prio && creq) begin fh = 1'b1; fi = 0; end
            else for (int i = 0; i < NS; i++)
               if (!fh && prio_slot[i] && el[i+1]) begin fh = 1'b1; fi = i + 1; end
         end
         if (fh) begin
            exp = NR'(1) << fi; nt = 1'b0;
            tag = (fi == 0) ? "R5" : "R11";
         end else begin
            rh = 1'b0;
            for (int k = 1; k <= NR; k++) begin
               j = (m_last + k) % NR;
               if (!rh && el[j]) begin rh = 1'b1; nl = j; end
            end
            if (rh) begin
               exp = NR'(1) << nl;
               if (!m_turn) tag = "R6";
               else if (cpu_prio || prio_slot != 0) tag = "R7";
               else tag = "R8";
               nt = 1'b1;
            end else if (park_last) begin
               if ((m_gnt & {slot_en, 1'b1}) != 0) begin exp = m_gnt; tag = "R10"; end
               else begin exp = NR'(1); tag = "R4"; end
            end else begin
               exp = NR'(1); tag = "R9";
            end
         end
      end
      @(negedge clk);
      got = {slot_gnt, cpu_gnt};
      check(tag, got, exp);
      // R2: exactly one grant
      total++;
      if ($countones(got) != 1) begin
         bad++;
         $display("FAIL R2: actual=%b expected=one-hot", got);
      end
      // R4: no disabled slot granted after a strobe
      if (adv) check("R4", got & {~slot_en, 1'b0}, '0);
      m_gnt = exp; m_turn = nt; m_last = nl;
   endtask

   initial begin
      logic [NS-1:0] en_tab [4];
      en_tab[0] = 4'hF; en_tab[1] = 4'h5; en_tab[2] = 4'hA; en_tab[3] = 4'h3;
      repeat (3) @(negedge clk);
      // R1: CPU owns the bus under reset and after release
      check("R1", {slot_gnt, cpu_gnt}, NR'(1));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", {slot_gnt, cpu_gnt}, NR'(1));
      step(1'b0, 1'b0, 4'hF);
      check("R1", {slot_gnt, cpu_gnt}, NR'(1));
      for (int cp = 0; cp < 2; cp++)
         for (int ps = 0; ps < NS + 1; ps++)
            for (int pk = 0; pk < 2; pk++)
               for (int e = 0; e < 4; e++) begin
                  cpu_prio  = cp[0];
                  prio_slot = (ps == 0) ? '0 : NS'(1) << (ps - 1);
                  park_last = pk[0];
                  slot_en   = en_tab[e];
                  for (int n = 0; n < 40; n++) begin
                     logic fb;
                     fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
                     lfsr = {lfsr[14:0], fb};
                     if (lfsr[10:8] == 3'd0) step(lfsr[2:0] != 3'd0, 1'b0, '0);
                     else step(lfsr[2:0] != 3'd0, lfsr[3], lfsr[7:4]);
                  end
               end
      // R10 corner: owner slot disabled at a parking strobe
      cpu_prio = 1'b0; prio_slot = '0; park_last = 1'b1; slot_en = 4'hF;
      step(1'b1, 1'b0, 4'h4);
      step(1'b1, 1'b0, 4'h0);
      slot_en = 4'hB;
      step(1'b1, 1'b0, 4'h0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule